// File: doc/BRIEF.md
# Threshold-Gate Bidirectional Shifter

This block moves an M-bit word toward the most significant end or toward the least significant end by a binary-coded count, inserting zeros in every position the move leaves empty. It is built as two layers of threshold neurons. Each neuron forms a weighted sum of binary inputs and fires when that sum reaches its threshold. The circuit has no clock and no state. The result follows the inputs through exactly two neuron layers, whatever the value of M.

The hidden layer holds one gate neuron for every pairing of an output position with a source position. That is M gates per output and M squared in total. A gate fires only when three things hold: its source bit is 1, the count equals the distance between the two positions, and the direction input selects the side the source lies on. The direction input does not feed a selector. It raises the thresholds of the gates on the side that is not selected, by more than any excitation those gates can receive. Each output neuron fires when any gate in its group fires.

The block is meant as a combinational operand stage inside a datapath. The count and the direction are plain control inputs. The block does not handshake, because nothing is stored in it.

Top module: `tgs_bidir_shifter`

## Requirements
- R1: With a count of 0, the output equals the input word for either direction value.
- R2: With `dir_right` = 0 and a count c below M, output bit i equals input bit i−c when i ≥ c, and is 0 when i < c. The top c input bits are lost.
- R3: With `dir_right` = 1 and a count c below M, output bit i equals input bit i+c when i+c < M, and is 0 otherwise. The low c input bits are lost.
- R4: A count equal to M gives an all-zero output in both directions.
- R5: Count codes above M that the `amt` width can still encode (for example 9 to 15 when M = 8) also give an all-zero output.
- R6: Within each output group, at most one hidden gate is active. A word with a single bit set therefore yields at most one set output bit, placed according to R2 or R3.
- R7: With M = 5, the word 01010 moved right by 1 gives 00101, and moved left by 1 gives 10100.
- R8: Every combination of word, count and direction for M = 5 matches R1 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | M | Data word to be moved |
| amt | input | K = ceil(log2(M+1)) | Unsigned move distance, 0 to 2^K−1 |
| dir_right | input | 1 | 0 moves toward the MSB, 1 moves toward the LSB |
| dout | output | M | Moved word with zero fill |

## Verification
The bench aims at the counts where a threshold scheme tends to break. The first is a count of M, which has no gate at all; a design with an off-by-one in the group bounds would leak the top or bottom bit there. The second is the unused codes above M; if a mismatching code bit were not inhibited hard enough, these codes would alias onto a smaller count and pass shifted data. The third is the direction input. If the threshold penalty were too small, both sides of a group would fire at once, and the output would show the OR of a left move and a right move. Walking single bits in both directions catches that. The exhaustive 5-bit sweep and the 8-bit random sweep catch a gate wired to the wrong source.

// File: rtl/tgs_pkg.sv
package tgs_pkg;

  // Which side of its output position a gate's source bit lies on.
  typedef enum logic [1:0] {
    SIDE_NONE  = 2'd0,
    SIDE_LEFT  = 2'd1,
    SIDE_RIGHT = 2'd2
  } side_e;

  // Excitatory weight on the source data bit.
  localparam int DATA_W = 2;

  // Weight from code bit b: excitatory when the gate's offset has b set,
  // strongly inhibitory otherwise (outweighs every excitation together).
  function automatic int gate_weight(int offset, int bit_idx, int kbits);
    if (((offset >> bit_idx) & 1) == 1) return 2;
    return -(2 * kbits + 4);
  endfunction

  // Firing threshold: met only by the data bit plus every matching code bit.
  function automatic int gate_thresh(int offset, int kbits);
    int ones;
    ones = 0;
    for (int b = 0; b < kbits; b++) ones += (offset >> b) & 1;
    return 2 * (ones + 1);
  endfunction

  // Threshold raise applied to gates on the side not selected.
  function automatic int side_penalty(int kbits);
    return 4 * kbits + 8;
  endfunction

endpackage

// File: rtl/tgs_gate_neuron.sv
module tgs_gate_neuron #(
  parameter int              K      = 4,
  parameter int              OFFSET = 0,
  parameter tgs_pkg::side_e  SIDE   = tgs_pkg::SIDE_NONE
) (
  input  logic         src,
  input  logic [K-1:0] code,
  input  logic         dir_right,
  output logic         fire
);
  localparam int THR = tgs_pkg::gate_thresh(OFFSET, K);
  localparam int PEN = tgs_pkg::side_penalty(K);

  int excite;
  int thresh;

  always_comb begin
    excite = src ? tgs_pkg::DATA_W : 0;
    for (int b = 0; b < K; b++) begin
      if (code[b]) excite += tgs_pkg::gate_weight(OFFSET, b, K);
    end
    thresh = THR;
    if ((SIDE == tgs_pkg::SIDE_LEFT && dir_right) ||
        (SIDE == tgs_pkg::SIDE_RIGHT && !dir_right))
      thresh = THR + PEN;
    fire = (excite >= thresh);
  end

  // A firing gate implies its source is set and the code names its offset (R6).
  always_comb begin
    if (fire) begin
      p_gate_match_r6: assert (src && (code == K'(OFFSET)))
        else $error("gate fired on mismatching code or zero source");
    end
  end

  // A gate on the side not selected stays silent (R2/R3).
  always_comb begin
    if (SIDE == tgs_pkg::SIDE_LEFT && dir_right) begin
      p_left_quiet_r3: assert (!fire) else $error("left gate active in right mode");
    end
    if (SIDE == tgs_pkg::SIDE_RIGHT && !dir_right) begin
      p_right_quiet_r2: assert (!fire) else $error("right gate active in left mode");
    end
  end

endmodule

// File: rtl/tgs_or_neuron.sv
module tgs_or_neuron #(
  parameter int N = 8
) (
  input  logic [N-1:0] act,
  output logic         y
);
  // Unit weights with a threshold of one: fires on any active input.
  localparam int OR_W   = 1;
  localparam int OR_THR = 1;

  int total;

  always_comb begin
    total = 0;
    for (int n = 0; n < N; n++) total += act[n] ? OR_W : 0;
    y = (total >= OR_THR);
  end

  // The hidden gates feeding one output are mutually exclusive (R6).
  always_comb begin
    p_group_onehot_r6: assert ($countones(act) <= 1)
      else $error("more than one gate active in a group");
  end

endmodule

// File: rtl/tgs_bidir_shifter.sv
module tgs_bidir_shifter #(
  parameter int M = 8,
  parameter int K = $clog2(M + 1)
) (
  input  logic [M-1:0] din,
  input  logic [K-1:0] amt,
  input  logic         dir_right,
  output logic [M-1:0] dout
);
  // Group i collects one gate per source position s. The gate's offset is
  // |i - s|; sources below i serve left moves, sources above i right moves.
  for (genvar i = 0; i < M; i++) begin : g_out
    logic [M-1:0] act;

    for (genvar s = 0; s < M; s++) begin : g_src
      if (s == i) begin : g_self
        tgs_gate_neuron #(.K(K), .OFFSET(0), .SIDE(tgs_pkg::SIDE_NONE)) u_gate (
          .src(din[s]), .code(amt), .dir_right(dir_right), .fire(act[s])
        );
      end else if (s < i) begin : g_left
        tgs_gate_neuron #(.K(K), .OFFSET(i - s), .SIDE(tgs_pkg::SIDE_LEFT)) u_gate (
          .src(din[s]), .code(amt), .dir_right(dir_right), .fire(act[s])
        );
      end else begin : g_right
        tgs_gate_neuron #(.K(K), .OFFSET(s - i), .SIDE(tgs_pkg::SIDE_RIGHT)) u_gate (
          .src(din[s]), .code(amt), .dir_right(dir_right), .fire(act[s])
        );
      end
    end

    tgs_or_neuron #(.N(M)) u_or (
      .act(act),
      .y  (dout[i])
    );
  end

  // A count of zero passes the word straight through (R1).
  always_comb begin
    if (amt == '0) begin
      p_identity_r1: assert (dout == din) else $error("zero count altered the word");
    end
  end

  // A count of M or any larger code clears the word (R4, R5).
  always_comb begin
    if (int'(amt) >= M) begin
      p_clear_r4: assert (dout == '0) else $error("full or over-range count left bits set");
    end
  end

endmodule

// File: tb/sim_tgs_bidir_shifter.sv
`timescale 1ns/1ps
module sim_tgs_bidir_shifter;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] d8;
  logic [3:0] a8;
  logic       r8;
  logic [7:0] q8;

  logic [4:0] d5;
  logic [2:0] a5;
  logic       r5;
  logic [4:0] q5;

  tgs_bidir_shifter #(.M(8)) u0 (.din(d8), .amt(a8), .dir_right(r8), .dout(q8));
  tgs_bidir_shifter #(.M(5)) u1 (.din(d5), .amt(a5), .dir_right(r5), .dout(q5));

  // Expected value built from the requirement text, width m up to 16.
  function automatic logic [15:0] ref_move(logic [15:0] d, int c, bit right, int m);
    logic [15:0] mask;
    logic [15:0] r;
    mask = 16'((32'd1 << m) - 1);
    r = '0;
    if (c >= m) return '0;
    for (int i = 0; i < m; i++) begin
      if (!right && i >= c) r[i] = d[i - c];
      if (right && i + c < m) r[i] = d[i + c];
    end
    return r & mask;
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive8(logic [7:0] d, int c, bit r);
    @(negedge clk);
    d8 = d; a8 = 4'(c); r8 = r;
    #1;
  endtask

  task automatic drive5(logic [4:0] d, int c, bit r);
    @(negedge clk);
    d5 = d; a5 = 3'(c); r5 = r;
    #1;
  endtask

  // Quiet inputs give a quiet output.
  task automatic t_idle;
    drive8(8'h00, 0, 1'b0);
    chk("R1 idle", {8'h0, q8}, 16'h0);
    drive5(5'h00, 0, 1'b0);
    chk("R1 idle5", {11'h0, q5}, 16'h0);
  endtask

  task automatic t_identity;
    for (int r = 0; r < 2; r++) begin
      drive8(8'hA7, 0, r[0]);
      chk("R1 identity", {8'h0, q8}, 16'h00A7);
      drive8(8'h5C, 0, r[0]);
      chk("R1 identity", {8'h0, q8}, 16'h005C);
    end
  endtask

  task automatic t_left;
    for (int c = 0; c < 8; c++) begin
      drive8(8'hFF, c, 1'b0);
      chk("R2 left ones", {8'h0, q8}, ref_move(16'hFF, c, 1'b0, 8));
      drive8(8'hB6, c, 1'b0);
      chk("R2 left pattern", {8'h0, q8}, ref_move(16'hB6, c, 1'b0, 8));
    end
  endtask

  task automatic t_right;
    for (int c = 0; c < 8; c++) begin
      drive8(8'hFF, c, 1'b1);
      chk("R3 right ones", {8'h0, q8}, ref_move(16'hFF, c, 1'b1, 8));
      drive8(8'h6D, c, 1'b1);
      chk("R3 right pattern", {8'h0, q8}, ref_move(16'h6D, c, 1'b1, 8));
    end
  endtask

  task automatic t_full;
    drive8(8'hFF, 8, 1'b0);
    chk("R4 full left", {8'h0, q8}, 16'h0);
    drive8(8'hFF, 8, 1'b1);
    chk("R4 full right", {8'h0, q8}, 16'h0);
    drive5(5'h1F, 5, 1'b1);
    chk("R4 full right5", {11'h0, q5}, 16'h0);
  endtask

  task automatic t_overrange;
    for (int c = 9; c < 16; c++) begin
      for (int r = 0; r < 2; r++) begin
        drive8(8'hFF, c, r[0]);
        chk("R5 over-range", {8'h0, q8}, 16'h0);
      end
    end
  endtask

  task automatic t_single_bit;
    for (int b = 0; b < 8; b++) begin
      for (int c = 0; c < 9; c++) begin
        for (int r = 0; r < 2; r++) begin
          drive8(8'(1 << b), c, r[0]);
          checks++;
          if ($countones(q8) > 1) begin
            errors++;
            $display("FAIL R6 one-hot: got %h expected at most one bit", q8);
          end
          chk("R6 single bit", {8'h0, q8}, ref_move(16'(1 << b), c, r[0], 8));
        end
      end
    end
  endtask

  task automatic t_example;
    drive5(5'b01010, 1, 1'b1);
    chk("R7 right example", {11'h0, q5}, 16'b00101);
    drive5(5'b01010, 1, 1'b0);
    chk("R7 left example", {11'h0, q5}, 16'b10100);
  endtask

  task automatic t_sweep5;
    for (int d = 0; d < 32; d++) begin
      for (int c = 0; c < 8; c++) begin
        for (int r = 0; r < 2; r++) begin
          drive5(5'(d), c, r[0]);
          chk("R8 sweep", {11'h0, q5}, ref_move(16'(d), c, r[0], 5));
        end
      end
    end
  endtask

  task automatic t_random8;
    for (int n = 0; n < 300; n++) begin
      logic [7:0] d;
      int c;
      bit r;
      d = 8'($urandom);
      c = int'($urandom % 16);
      r = 1'($urandom);
      drive8(d, c, r);
      chk("R2/R3 random", {8'h0, q8}, ref_move({8'h0, d}, c, r, 8));
    end
  endtask

  initial begin
    d8 = '0; a8 = '0; r8 = 1'b0;
    d5 = '0; a5 = '0; r5 = 1'b0;
    t_idle();
    t_identity();
    t_left();
    t_right();
    t_full();
    t_overrange();
    t_single_bit();
    t_example();
    t_sweep5();
    t_random8();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule